// File: doc/BRIEF.md
# Packed Unsigned Saturating Adder-Subtractor

This block does unsigned saturating arithmetic on packed data. It takes two 32-bit operands and splits them into either two 16-bit halfwords or four 8-bit bytes. Each lane is added or subtracted on its own, with no carry or borrow passing into the next lane. The true result of a lane can be too large or below zero. In that case the output lane is clamped to the largest value the lane can hold, or to zero.

Two exchange forms pair each halfword of the first operand with the opposite halfword of the second operand. They apply opposite operations in the two halves. This is useful for complex-number style butterflies on packed 16-bit data. The block drives no condition flags.

A 4-bit saturation indicator, one bit per byte lane, is provided for observation during verification. By default the result, the indicator and a valid strobe are registered, so they appear one clock after the operands.

Top module: `psat_addsub`

## Requirements
- R1: With `op_sel` = 3'b000, each 16-bit lane (bits [15:0] and [31:16]) of `result` is `opnd_a` lane plus `opnd_b` lane. A sum of 65536 or more gives 16'hFFFF.
- R2: With `op_sel` = 3'b001, each of the four 8-bit lanes (bits [7:0], [15:8], [23:16], [31:24]) is the sum of the matching operand bytes, clamped to 8'hFF. No carry passes between lanes.
- R3: With `op_sel` = 3'b010, each 16-bit lane is `opnd_a` lane minus `opnd_b` lane. A negative difference gives 16'h0000.
- R4: With `op_sel` = 3'b011, each 8-bit lane is the byte difference, clamped to 8'h00 when negative. No borrow passes between lanes.
- R5: With `op_sel` = 3'b100, `result[15:0]` = sat16(`opnd_a[15:0]` − `opnd_b[31:16]`) and `result[31:16]` = sat16(`opnd_a[31:16]` + `opnd_b[15:0]`).
- R6: With `op_sel` = 3'b101, `result[15:0]` = sat16(`opnd_a[15:0]` + `opnd_b[31:16]`) and `result[31:16]` = sat16(`opnd_a[31:16]` − `opnd_b[15:0]`).
- R7: With `op_sel` = 3'b110 or 3'b111, `result` and `sat_flags` are all zero.
- R8: `sat_flags[i]` is 1 exactly when byte lane i (bits [8i+7:8i]) was clamped. In 16-bit and exchange forms, both bits of a halfword (bits 1:0 for the low half, bits 3:2 for the high half) carry that halfword's clamp indicator.
- R9: With `REG_OUT` = 1, `result`, `sat_flags` and `valid_out` reflect the operands, `op_sel` and `valid_in` captured at the previous rising clock edge. The data path captures every cycle, whatever the value of `valid_in`.
- R10: A synchronous active-high `rst` clears `valid_out`, `result` and `sat_flags` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands valid |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| valid_out | output | 1 | Result valid |
| result | output | 32 | Packed saturated result |
| sat_flags | output | 4 | Per-byte-lane clamp indicator (verification only) |

## Verification
The hardest cases to reach are lanes sitting exactly on the clamp boundary. Examples are a sum of exactly 2^w − 1 next to one of 2^w, a difference of exactly zero next to −1, and different lanes in the same word saturating in opposite directions. Uniform random operands almost never hit these. The stimulus therefore builds operands from a small set of corner values (zero, one, mid-range neighbours, all-ones) and rotates them through every lane position under every operation code. It also mixes corner lanes with random lanes inside the same word, so that an error leaking across a lane border shows up.

// File: rtl/psat_pkg.sv
package psat_pkg;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'b000,
    OP_ADD8  = 3'b001,
    OP_SUB16 = 3'b010,
    OP_SUB8  = 3'b011,
    OP_XSA   = 3'b100,
    OP_XAS   = 3'b101,
    OP_NOP6  = 3'b110,
    OP_NOP7  = 3'b111
  } psat_op_e;

  localparam int unsigned HALF_LANES = 2;
  localparam int unsigned QUAD_LANES = 4;

  function automatic logic is_half_op(input psat_op_e op);
    return (op == OP_ADD16) || (op == OP_SUB16) || (op == OP_XSA) || (op == OP_XAS);
  endfunction

  function automatic logic is_quad_op(input psat_op_e op);
    return (op == OP_ADD8) || (op == OP_SUB8);
  endfunction

endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         clamp
);

  logic [W:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
    clamp = wide[W];
    if (!wide[W])  y = wide[W-1:0];
    else if (sub)  y = '0;
    else           y = '1;
  end

endmodule

// File: rtl/psat_half_path.sv
module psat_half_path
  import psat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  psat_op_e            op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   y,
  output logic [HALF_LANES-1:0] clamp
);

  localparam int unsigned HW = DATA_W / HALF_LANES;

  logic crossed;
  assign crossed = (op == OP_XSA) || (op == OP_XAS);

  for (genvar h = 0; h < HALF_LANES; h++) begin : g_half
    localparam int unsigned OPP = HALF_LANES - 1 - h;
    logic [HW-1:0] b_pick;
    logic          do_sub;

    assign b_pick = crossed ? b[OPP*HW +: HW] : b[h*HW +: HW];
    assign do_sub = (op == OP_SUB16) ||
                    ((op == OP_XSA) && (h == 0)) ||
                    ((op == OP_XAS) && (h != 0));

    psat_lane #(.W(HW)) u_lane (
      .a     (a[h*HW +: HW]),
      .b     (b_pick),
      .sub   (do_sub),
      .y     (y[h*HW +: HW]),
      .clamp (clamp[h])
    );
  end

endmodule

// File: rtl/psat_quad_path.sv
module psat_quad_path
  import psat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  sub,
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  output logic [DATA_W-1:0]     y,
  output logic [QUAD_LANES-1:0] clamp
);

  localparam int unsigned QW = DATA_W / QUAD_LANES;

  for (genvar q = 0; q < QUAD_LANES; q++) begin : g_quad
    psat_lane #(.W(QW)) u_lane (
      .a     (a[q*QW +: QW]),
      .b     (b[q*QW +: QW]),
      .sub   (sub),
      .y     (y[q*QW +: QW]),
      .clamp (clamp[q])
    );
  end

endmodule

// File: rtl/psat_addsub.sv
module psat_addsub
  import psat_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              valid_out,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        sat_flags
);

  localparam int unsigned QW = DATA_W / QUAD_LANES;
  localparam int unsigned BYTES_PER_HALF = QUAD_LANES / HALF_LANES;

  psat_op_e op;
  assign op = psat_op_e'(op_sel);

  logic [DATA_W-1:0]     half_y, quad_y;
  logic [HALF_LANES-1:0] half_c;
  logic [QUAD_LANES-1:0] quad_c;
  logic [QUAD_LANES-1:0] half_c_spread;

  psat_half_path #(.DATA_W(DATA_W)) u_half (
    .op    (op),
    .a     (opnd_a),
    .b     (opnd_b),
    .y     (half_y),
    .clamp (half_c)
  );

  psat_quad_path #(.DATA_W(DATA_W)) u_quad (
    .sub   (op == OP_SUB8),
    .a     (opnd_a),
    .b     (opnd_b),
    .y     (quad_y),
    .clamp (quad_c)
  );

  for (genvar q = 0; q < QUAD_LANES; q++) begin : g_spread
    assign half_c_spread[q] = half_c[q / BYTES_PER_HALF];
  end

  logic [DATA_W-1:0]     nxt_y;
  logic [QUAD_LANES-1:0] nxt_c;

  always_comb begin
    if (is_half_op(op)) begin
      nxt_y = half_y;
      nxt_c = half_c_spread;
    end else if (is_quad_op(op)) begin
      nxt_y = quad_y;
      nxt_c = quad_c;
    end else begin
      nxt_y = '0;
      nxt_c = '0;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_out <= 1'b0;
        result    <= '0;
        sat_flags <= '0;
      end else begin
        valid_out <= valid_in;
        result    <= nxt_y;
        sat_flags <= nxt_c;
      end
    end

    assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (!valid_out && (result == '0) && (sat_flags == '0)));

    assert_valid_set_R9: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);

    assert_valid_clear_R9: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (op_sel[2:1] == 2'b11) |=> ((result == '0) && (sat_flags == '0)));

    for (genvar q = 0; q < QUAD_LANES; q++) begin : g_chk
      assert_add_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
        ((op_sel == OP_ADD8) || (op_sel == OP_ADD16))
          |=> (!sat_flags[q] || (result[q*QW +: QW] == '1)));

      assert_sub_floor_R8: assert property (@(posedge clk) disable iff (rst)
        ((op_sel == OP_SUB8) || (op_sel == OP_SUB16))
          |=> (!sat_flags[q] || (result[q*QW +: QW] == '0)));

      assert_add8_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ADD8)
          |=> (result[q*QW +: QW] >= $past(opnd_a[q*QW +: QW])));

      assert_sub8_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SUB8)
          |=> (result[q*QW +: QW] <= $past(opnd_a[q*QW +: QW])));
    end
  end else begin : g_comb
    assign valid_out = valid_in;
    assign result    = nxt_y;
    assign sat_flags = nxt_c;
  end

endmodule

// File: tb/psat_addsub_tb.sv
module psat_addsub_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [2:0]  op_sel = 3'b000;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        valid_out;
  logic [31:0] result;
  logic [3:0]  sat_flags;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  psat_addsub #(.DATA_W(32), .REG_OUT(1'b1)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .valid_out (valid_out),
    .result    (result),
    .sat_flags (sat_flags)
  );

  function automatic int clampv(input int v, input int w);
    if (v >= (1 << w)) return (1 << w) - 1;
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic void model(input logic [2:0] op, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] r,
                                output logic [3:0] f);
    int v0, v1, c0, c1;
    r = '0;
    f = '0;
    case (op)
      3'b001, 3'b011: begin
        for (int q = 0; q < 4; q++) begin
          int x, c;
          x = (op == 3'b001) ? int'(a[q*8 +: 8]) + int'(b[q*8 +: 8])
                             : int'(a[q*8 +: 8]) - int'(b[q*8 +: 8]);
          c = clampv(x, 8);
          r[q*8 +: 8] = c[7:0];
          f[q] = (c != x);
        end
      end
      3'b110, 3'b111: ;
      default: begin
        case (op)
          3'b000: begin v0 = int'(a[15:0]) + int'(b[15:0]);  v1 = int'(a[31:16]) + int'(b[31:16]); end
          3'b010: begin v0 = int'(a[15:0]) - int'(b[15:0]);  v1 = int'(a[31:16]) - int'(b[31:16]); end
          3'b100: begin v0 = int'(a[15:0]) - int'(b[31:16]); v1 = int'(a[31:16]) + int'(b[15:0]);  end
          default: begin v0 = int'(a[15:0]) + int'(b[31:16]); v1 = int'(a[31:16]) - int'(b[15:0]); end
        endcase
        c0 = clampv(v0, 16);
        c1 = clampv(v1, 16);
        r = {c1[15:0], c0[15:0]};
        f = {{2{c1 != v1}}, {2{c0 != v0}}};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic v);
    logic [31:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; valid_in = v;
    model(op, a, b, er, ef);
    @(negedge clk);
    n_chk++;
    if (result !== er) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h",
               tag_of(op), op, a, b, result, er);
    end
    if (sat_flags !== ef) begin
      n_fail++;
      $display("FAIL R8 op=%b a=%h b=%h sat_flags actual=%b expected=%b",
               op, a, b, sat_flags, ef);
    end
    if (valid_out !== v) begin
      n_fail++;
      $display("FAIL R9 valid_out actual=%b expected=%b", valid_out, v);
    end
  endtask

  logic [15:0] c16 [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
  logic [7:0]  c8  [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};

  function automatic logic [31:0] pick_word(input int sel);
    logic [31:0] w;
    w = $urandom;
    if (sel == 1) begin
      for (int q = 0; q < 4; q++)
        if ($urandom_range(1, 0) == 1) w[q*8 +: 8] = c8[$urandom_range(4, 0)];
    end else if (sel == 2) begin
      w = {c16[$urandom_range(4, 0)], c16[$urandom_range(4, 0)]};
    end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17C3));
    // R10: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_out !== 1'b0 || result !== '0 || sat_flags !== '0) begin
      n_fail++;
      $display("FAIL R10 reset state actual=%b/%h/%b expected=0/00000000/0000",
               valid_out, result, sat_flags);
    end
    @(negedge clk);
    rst = 1'b0;

    // Directed corners: 16-bit values in both halves, all ops (R1..R8)
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          apply(3'(op), {c16[i], c16[j]}, {c16[j], c16[i]}, 1'b1);
          apply(3'(op), {c16[j], c16[i]}, {c16[i], c16[i]}, (i + j) % 2 == 0);
        end

    // Directed corners: 8-bit values rotated through every lane (R2, R4)
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int rot = 0; rot < 4; rot++) begin
            logic [31:0] a, b;
            for (int q = 0; q < 4; q++) begin
              a[q*8 +: 8] = c8[(i + q + rot) % 5];
              b[q*8 +: 8] = c8[(j + 2*q + rot) % 5];
            end
            apply(3'(op), a, b, 1'b1);
          end

    // Boundary neighbours: exact ceiling / zero difference (R1, R3, R2, R4)
    apply(3'b000, 32'h0001_FFFE, 32'hFFFF_0001, 1'b1);
    apply(3'b000, 32'h0001_FFFF, 32'hFFFE_0001, 1'b1);
    apply(3'b010, 32'h1234_0005, 32'h1235_0005, 1'b1);
    apply(3'b001, 32'hFE01_80FF, 32'h01FF_7F00, 1'b1);
    apply(3'b011, 32'h0001_8000, 32'h0102_7F00, 1'b1);
    apply(3'b100, 32'hFFFF_0000, 32'h0001_0001, 1'b1);
    apply(3'b101, 32'h0000_FFFF, 32'h0001_0001, 1'b1);

    // Random mix with corner lanes
    for (int k = 0; k < 3000; k++)
      apply(3'($urandom_range(7, 0)), pick_word($urandom_range(2, 0)),
            pick_word($urandom_range(2, 0)), 1'($urandom_range(1, 0)));

    // R10: reset in mid-stream with valid_in high
    @(negedge clk);
    valid_in = 1'b1; op_sel = 3'b000; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
    rst = 1'b1;
    @(negedge clk);
    n_chk++;
    if (valid_out !== 1'b0 || result !== '0 || sat_flags !== '0) begin
      n_fail++;
      $display("FAIL R10 mid-run reset actual=%b/%h/%b expected=0/00000000/0000",
               valid_out, result, sat_flags);
    end
    rst = 1'b0;
    apply(3'b000, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule